// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of an 8-bit successive-approximation A/D converter. Software programs a single 8-bit control word. The word selects one of eight analog inputs, sets the conversion rate and enables the converter. Software then toggles a start bit to clear the converter or to launch a conversion. The block steers a one-hot select to an external analog multiplexer and presents a trial code to an external DAC. It reads back a one-bit comparator decision and builds the result one bit at a time, from the most significant bit down.

The conversion rate comes from a divider on the system clock. The divider makes a single-cycle step enable every 2, 4, 8 or 16 system cycles. With a 12 MHz system clock these periods give 6, 3, 1.5 and 0.75 MHz. No second clock domain is created.

Completion is reported by an active-low flag in the top bit of the control word. The 8-bit result sits in its own read register.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, ctl_rdata reads 0x80 (only the done flag in bit 7 is high), res_rdata reads 0 and ch_sel is all zero.
- R2: While the enable bit (bit 6) is 1, ch_sel is one-hot with bit n set for the channel code n latched at the last start. Codes 0 to 5 pick analog inputs, 6 picks the low reference and 7 picks the high reference. While the enable bit is 0, ch_sel is zero.
- R3: A write that raises the start bit (bit 5) from 0 to 1 while enabled clears res_rdata to 0 and sets bit 7 to 1 at that same clock edge.
- R4: A write that lowers the start bit from 1 to 0 while enabled begins a conversion, and bit 7 reads 1 until the conversion finishes.
- R5: The rate field (bits 4..3) sets the step period: 00 gives 2 system cycles, 01 gives 4, 10 gives 8 and 11 gives 16. A conversion finishes exactly 8 step periods after the edge that started it.
- R6: The search tests the bits from the MSB down. The bit under test is set on dac_code. It is kept if cmp_in is 1 at its step and cleared otherwise, so a comparator that reports dac_code <= v yields the result v.
- R7: Bit 7 falls to 0 at the same clock edge at which res_rdata loads the final code.
- R8: While the enable bit is 0, start bit edges have no effect: res_rdata and bit 7 keep their values.
- R9: The channel and rate fields are sampled at the start. Writes to them during a conversion change neither the step timing nor ch_sel until the next start.
- R10: Clearing the enable bit during a conversion aborts it. Bit 7 stays 1 and res_rdata keeps its previous value.
- R11: Bits 6..0 of ctl_rdata return the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 8 | Control word write data (bit 7 ignored) |
| ctl_rdata | output | 8 | Control word readback, bit 7 is the active-low done flag |
| res_rdata | output | 8 | Conversion result |
| cmp_in | input | 1 | Comparator decision, 1 when input is at or above dac_code |
| dac_code | output | 8 | Trial code for the external DAC |
| ch_sel | output | 8 | One-hot analog multiplexer select |

## Verification
The assertions assume that cmp_in is a function of dac_code and a fixed analog level that does not change during a conversion. The bench models the comparator combinationally as dac_code <= v and holds v constant across each conversion. The assertions also assume that software changes the start bit only through full control writes. The bench sends every start edge as a complete write of the control word. During a conversion it changes the rate and channel fields only with the start bit held at 0 and the enable bit at 1, so that no unintended edge occurs.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
    localparam int ADC_W  = 8;
    localparam int CH_W   = 3;
    localparam int N_CH   = 1 << CH_W;
    localparam int RATE_W = 2;
    localparam int CNT_W  = 1 << RATE_W;
    localparam int STEP_W = $clog2(ADC_W);

    localparam int BIT_EOC   = 7;
    localparam int BIT_EN    = 6;
    localparam int BIT_START = 5;

    typedef struct packed {
        logic              en;
        logic              start;
        logic [RATE_W-1:0] rate;
        logic [CH_W-1:0]   chan;
    } ctl_t;

    typedef struct packed {
        logic go;
        logic clr;
        logic abort;
    } evt_t;

    function automatic logic [CNT_W-1:0] rate_limit(input logic [RATE_W-1:0] r);
        logic [CNT_W:0] n;
        n = ({{CNT_W{1'b0}}, 1'b1} << (r + 1));
        return CNT_W'(n - 1);
    endfunction
endpackage

// File: rtl/sarc_regs.sv
module sarc_regs
    import sarc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output ctl_t       ctl,
    output evt_t       evt
);
    ctl_t ctl_q;
    ctl_t ctl_n;

    assign ctl_n = ctl_t'(wdata[BIT_EN:0]);

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (we)
            ctl_q <= ctl_n;
    end

    always_comb begin
        evt.clr   = we && ctl_n.en && ctl_n.start && !ctl_q.start;
        evt.go    = we && ctl_n.en && !ctl_n.start && ctl_q.start;
        evt.abort = we && ctl_q.en && !ctl_n.en;
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/sarc_clkdiv.sv
module sarc_clkdiv
    import sarc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [RATE_W-1:0] rate,
    input  logic              run,
    output logic              tick
);
    logic [RATE_W-1:0] rate_q;
    logic [CNT_W-1:0]  cnt_q;

    assign tick = run && (cnt_q == rate_limit(rate_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            rate_q <= rate;
            cnt_q  <= '0;
        end else if (tick) begin
            cnt_q  <= '0;
        end else if (run) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sarc_chdec.sv
module sarc_chdec
    import sarc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [CH_W-1:0] chan,
    input  logic            en,
    output logic [N_CH-1:0] sel
);
    logic [CH_W-1:0] chan_q;

    always_ff @(posedge clk) begin
        if (rst)
            chan_q <= '0;
        else if (load)
            chan_q <= chan;
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_sel
        assign sel[i] = en && (chan_q == CH_W'(i));
    end
endmodule

// File: rtl/sarc_engine.sv
module sarc_engine
    import sarc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  evt_t             evt,
    input  logic             tick,
    input  logic             cmp,
    output logic             busy,
    output logic             eoc_n,
    output logic [ADC_W-1:0] result,
    output logic [ADC_W-1:0] trial
);
    logic [STEP_W-1:0] step_q;
    logic [ADC_W-1:0]  decided;
    logic [ADC_W-1:0]  step_mask;

    assign step_mask = {{(ADC_W-1){1'b0}}, 1'b1} << step_q;
    assign decided   = cmp ? trial : (trial & ~step_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            eoc_n  <= 1'b1;
            result <= '0;
            trial  <= '0;
            step_q <= '0;
        end else if (evt.abort) begin
            busy   <= 1'b0;
        end else if (evt.clr) begin
            busy   <= 1'b0;
            eoc_n  <= 1'b1;
            result <= '0;
        end else if (evt.go) begin
            busy   <= 1'b1;
            eoc_n  <= 1'b1;
            trial  <= {1'b1, {(ADC_W-1){1'b0}}};
            step_q <= STEP_W'(ADC_W-1);
        end else if (busy && tick) begin
            if (step_q == '0) begin
                busy   <= 1'b0;
                eoc_n  <= 1'b0;
                result <= decided;
                trial  <= decided;
            end else begin
                trial  <= decided | (step_mask >> 1);
                step_q <= step_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
    import sarc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    output logic [7:0]       ctl_rdata,
    output logic [ADC_W-1:0] res_rdata,
    input  logic             cmp_in,
    output logic [ADC_W-1:0] dac_code,
    output logic [N_CH-1:0]  ch_sel
);
    ctl_t ctl;
    evt_t evt;
    logic tick;
    logic busy;
    logic eoc_n;
    logic go;

    assign go = evt.go;

    sarc_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl   (ctl),
        .evt   (evt)
    );

    sarc_clkdiv u_div (
        .clk  (clk),
        .rst  (rst),
        .load (evt.go),
        .rate (ctl.rate),
        .run  (busy),
        .tick (tick)
    );

    sarc_chdec u_dec (
        .clk  (clk),
        .rst  (rst),
        .load (evt.go),
        .chan (ctl.chan),
        .en   (ctl.en),
        .sel  (ch_sel)
    );

    sarc_engine u_eng (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .tick   (tick),
        .cmp    (cmp_in),
        .busy   (busy),
        .eoc_n  (eoc_n),
        .result (res_rdata),
        .trial  (dac_code)
    );

    assign ctl_rdata = {eoc_n, ctl};
endmodule

// File: rtl/sarc_chk.sv
module sarc_chk
    import sarc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [7:0]       ctl_rdata,
    input logic [ADC_W-1:0] res,
    input logic [N_CH-1:0]  ch_sel,
    input logic             go,
    input logic             busy
);
    // R2: select is never more than one-hot
    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_sel));

    // R2: no input selected while disabled
    p_sel_off_r2: assert property (@(posedge clk) disable iff (rst)
        !ctl_rdata[BIT_EN] |-> (ch_sel == '0));

    // R9: select holds during a conversion unless a fresh start occurred
    p_sel_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(go) && ctl_rdata[BIT_EN] && $past(ctl_rdata[BIT_EN]))
        |-> $stable(ch_sel));

    // R7: the result only moves when cleared or when the done flag falls
    p_res_moves_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(res) |-> (res == '0 || $fell(ctl_rdata[BIT_EOC])));

    // R7: done flag falls only at the end of a running conversion
    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_rdata[BIT_EOC]) |-> $past(busy));

    // R8: completion requires the converter to be enabled
    p_done_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_rdata[BIT_EOC]) |-> $past(ctl_rdata[BIT_EN]));
endmodule

bind sar_adc_seq sarc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_rdata (ctl_rdata),
    .res       (res_rdata),
    .ch_sel    (ch_sel),
    .go        (go),
    .busy      (busy)
);

// File: tb/sim_sar_adc_seq.sv
module sim_sar_adc_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] res;
    logic [7:0] dac;
    logic [7:0] sel;
    logic [7:0] vin = 8'h00;
    logic       cmp;
    int         checks = 0;
    int         fails = 0;

    always #2 clk = ~clk;

    assign cmp = (dac <= vin);

    sar_adc_seq u0 (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (we),
        .ctl_wdata (wdata),
        .ctl_rdata (rdata),
        .res_rdata (res),
        .cmp_in    (cmp),
        .dac_code  (dac),
        .ch_sel    (sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        we = 1'b1;
        wdata = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    function automatic logic [7:0] cw(input bit en, input bit st,
                                      input logic [1:0] rate, input logic [2:0] ch);
        return {1'b0, en, st, rate, ch};
    endfunction

    task automatic t_reset();
        chk(rdata == 8'h80, "R1 ctl", rdata, 8'h80);
        chk(res == 8'h00, "R1 res", res, 0);
        chk(sel == 8'h00, "R1 sel", sel, 0);
    endtask

    task automatic t_convert(input logic [7:0] v, input logic [1:0] rate, input logic [2:0] ch);
        int n;
        n = 2 << rate;
        vin = v;
        wr(cw(1, 1, rate, ch));
        chk(res == 8'h00 && rdata[7], "R3 clear", {rdata[7], res}, 9'h100);
        wr(cw(1, 0, rate, ch));
        chk(dac == 8'h80, "R6 msb first", dac, 8'h80);
        chk(sel == (8'h01 << ch), "R2 sel", sel, 8'h01 << ch);
        chk(rdata[6:0] == cw(1, 0, rate, ch), "R11 readback", rdata[6:0], cw(1, 0, rate, ch));
        repeat (8 * n - 1) @(negedge clk);
        chk(rdata[7] == 1'b1, "R4 busy", rdata[7], 1);
        chk(rdata[7] == 1'b1, "R5 not before 8 steps", rdata[7], 1);
        @(negedge clk);
        chk(rdata[7] == 1'b0, "R5 R7 done", rdata[7], 0);
        chk(res == v, "R6 R7 result", res, v);
    endtask

    task automatic t_clear();
        wr(cw(1, 1, 2'd0, 3'd0));
        chk(res == 8'h00, "R3 result cleared", res, 0);
        chk(rdata[7] == 1'b1, "R3 flag set", rdata[7], 1);
    endtask

    task automatic t_off();
        logic [7:0] keep;
        keep = res;
        wr(8'h00);
        chk(sel == 8'h00, "R2 sel off", sel, 0);
        wr(cw(0, 1, 2'd0, 3'd3));
        chk(res == keep && rdata[7] == 1'b0, "R8 rise ignored", res, keep);
        wr(cw(0, 0, 2'd0, 3'd3));
        repeat (40) @(negedge clk);
        chk(res == keep && rdata[7] == 1'b0, "R8 fall ignored", res, keep);
    endtask

    task automatic t_fields();
        vin = 8'h5A;
        wr(cw(1, 1, 2'd0, 3'd2));
        wr(cw(1, 0, 2'd0, 3'd2));
        wr(cw(1, 0, 2'd3, 3'd5));
        chk(sel == 8'h04, "R9 sel held", sel, 8'h04);
        repeat (16 - 2 - 1) @(negedge clk);
        chk(rdata[7] == 1'b1, "R9 busy", rdata[7], 1);
        @(negedge clk);
        chk(rdata[7] == 1'b0 && res == 8'h5A, "R9 old rate kept", res, 8'h5A);
    endtask

    task automatic t_abort();
        logic [7:0] keep;
        keep = res;
        vin = 8'h11;
        wr(cw(1, 1, 2'd1, 3'd1));
        keep = res;
        wr(cw(1, 0, 2'd1, 3'd1));
        repeat (6) @(negedge clk);
        wr(cw(0, 0, 2'd1, 3'd1));
        repeat (60) @(negedge clk);
        chk(rdata[7] == 1'b1, "R10 flag stays", rdata[7], 1);
        chk(res == keep, "R10 result kept", res, keep);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_convert(8'hA5, 2'd0, 3'd0);
        t_convert(8'h00, 2'd1, 3'd6);
        t_convert(8'hFF, 2'd2, 3'd7);
        t_convert(8'h37, 2'd3, 3'd4);
        t_clear();
        t_convert(8'h80, 2'd0, 3'd5);
        t_off();
        t_fields();
        t_convert(8'h3C, 2'd1, 3'd1);
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule